// File: doc/BRIEF.md
# Raster Beam Position Counter with Display and Fetch Windows

This block tracks the position of a raster beam as a horizontal count and a vertical count. Both counts advance by one on every cycle in which the colour-clock step enable is high. Line length alternates with line parity, and a frame holds 262 lines. Software on a 16-bit register bus reads the current beam position through two read-only words.

Software also writes four window registers. Two of them bound the visible display area, with horizontal and vertical start and stop values. The other two bound the horizontal range in which display data is fetched. The block decodes each written word into 9-bit limits. The stop register fills in the ninth bits that are not written, using fixed rules. Two flags tell the rest of the video logic whether the beam is currently inside each window.

The bus uses word indices: index = byte offset / 2. Reads are registered. The data for a read appears on `rdata_o` during the cycle after `rd_i` was high.

Top module: `beam_window_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, both counts and all window limits are zero. `rdata_o` is 0 and `disp_win_o` is 0. `fetch_win_o` is 1, because 0 lies inside the range 0..0.
- R2: The horizontal count increments only on cycles with `step_i` high. It returns to 0 after position 226 on even lines and after position 227 on odd lines, so an odd line is one step longer.
- R3: The vertical count increments on the step that wraps the horizontal count. After line 261 it returns to 0.
- R4: A read of word index 0x02 (byte offset 0x004) returns bit 8 of the vertical count in bit 0 of `rdata_o`. All other bits are 0.
- R5: A read of word index 0x03 (byte offset 0x006) returns the horizontal count in bits 15:8 and vertical count bits 7:0 in bits 7:0. The value is sampled at the clock edge where `rd_i` is high.
- R6: A read of any other index returns 0. `rdata_o` is 0 in every cycle that does not follow a read. Writes to indices 0x02 and 0x03 leave the position unchanged.
- R7: A write to index 0x47 (byte 0x08E) sets horizontal start to {0, data[7:0]} and vertical start to {0, data[15:8]}.
- R8: A write to index 0x48 (byte 0x090) sets horizontal stop to {1, data[7:0]} and vertical stop to {~data[15], data[15:8]}.
- R9: A write to index 0x49 (byte 0x092) sets fetch start to {data[7:2], 000}. A write to index 0x4A (byte 0x094) sets fetch stop the same way.
- R10: `disp_win_o` is 1 exactly when hstart <= h < hstop and vstart <= v < vstop, using 9-bit unsigned compares.
- R11: `fetch_win_o` is 1 exactly when fetch start <= 2*h <= fetch stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Colour-clock enable; advances the beam by one position |
| addr_i | input | 8 | Register word index (byte offset / 2) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data, valid the cycle after `rd_i` |
| disp_win_o | output | 1 | Beam inside the display window |
| fetch_win_o | output | 1 | Beam inside the fetch window |

## Verification
A wrong line-length or frame-wrap decision only shows up at a line or frame boundary. It then shifts every later position read, and moves every later window-flag transition. The bench therefore reads the position at both line parities and past line 256, and it compares both flags against a model on every step of more than one frame. If a window limit is decoded wrongly, the flag edge moves by a whole line or column. That is seen within one line of the faulty row or column, or within one frame for the vertical limits.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 8;
  localparam int unsigned HW = 8;
  localparam int unsigned VW = 9;
  localparam int unsigned LW = 9;

  // word indices (byte offset / 2)
  localparam logic [AW-1:0] IDX_POS_HI   = 8'h02;
  localparam logic [AW-1:0] IDX_POS_LO   = 8'h03;
  localparam logic [AW-1:0] IDX_WIN_BEG  = 8'h47;
  localparam logic [AW-1:0] IDX_WIN_END  = 8'h48;
  localparam logic [AW-1:0] IDX_FET_BEG  = 8'h49;
  localparam logic [AW-1:0] IDX_FET_END  = 8'h4A;

  typedef struct packed {
    logic [LW-1:0] h_beg;
    logic [LW-1:0] h_end;
    logic [LW-1:0] v_beg;
    logic [LW-1:0] v_end;
    logic [LW-1:0] f_beg;
    logic [LW-1:0] f_end;
  } win_lim_t;
endpackage

// File: rtl/bw_beam_counter.sv
module bw_beam_counter #(
  parameter int unsigned H_BASE  = 227,
  parameter int unsigned V_LINES = 262,
  parameter int unsigned HW      = 8,
  parameter int unsigned VW      = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [HW-1:0] hpos_o,
  output logic [VW-1:0] vpos_o
);
  localparam logic [HW-1:0] H_LAST_EVEN = HW'(H_BASE - 1);
  localparam logic [VW-1:0] V_LAST      = VW'(V_LINES - 1);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic [HW-1:0] h_last;
  logic          line_end;
  logic          frame_end;

  // odd lines run one position longer
  assign h_last    = H_LAST_EVEN + HW'(v_q[0]);
  assign line_end  = (h_q == h_last);
  assign frame_end = (v_q == V_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (step_i) begin
      if (line_end) begin
        h_q <= '0;
        v_q <= frame_end ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  assign hpos_o = h_q;
  assign vpos_o = v_q;
endmodule

// File: rtl/bw_window_regs.sv
module bw_window_regs
  import bw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output win_lim_t      lim_o
);
  win_lim_t lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        IDX_WIN_BEG: begin
          lim_q.h_beg <= {1'b0, wdata_i[7:0]};
          lim_q.v_beg <= {1'b0, wdata_i[15:8]};
        end
        IDX_WIN_END: begin
          // ninth bits are implied: h always high, v from inverted msb
          lim_q.h_end <= {1'b1, wdata_i[7:0]};
          lim_q.v_end <= {~wdata_i[15], wdata_i[15:8]};
        end
        IDX_FET_BEG: lim_q.f_beg <= {wdata_i[7:2], 3'b000};
        IDX_FET_END: lim_q.f_end <= {wdata_i[7:2], 3'b000};
        default: ;
      endcase
    end
  end

  assign lim_o = lim_q;
endmodule

// File: rtl/bw_window_cmp.sv
module bw_window_cmp
  import bw_pkg::*;
#(
  parameter int unsigned FETCH_SH = 1
) (
  input  logic [HW-1:0] hpos_i,
  input  logic [VW-1:0] vpos_i,
  input  win_lim_t      lim_i,
  output logic          disp_o,
  output logic          fetch_o
);
  logic [LW-1:0] h_ext;
  logic [LW-1:0] h_fetch;
  logic          in_h;
  logic          in_v;

  assign h_ext = LW'(hpos_i);

  generate
    if (FETCH_SH == 0) begin : g_fetch_direct
      assign h_fetch = h_ext;
    end else begin : g_fetch_scaled
      assign h_fetch = LW'({hpos_i, {FETCH_SH{1'b0}}});
    end
  endgenerate

  assign in_h    = (h_ext >= lim_i.h_beg) && (h_ext < lim_i.h_end);
  assign in_v    = (LW'(vpos_i) >= lim_i.v_beg) && (LW'(vpos_i) < lim_i.v_end);
  assign disp_o  = in_h && in_v;
  assign fetch_o = (h_fetch >= lim_i.f_beg) && (h_fetch <= lim_i.f_end);
endmodule

// File: rtl/bw_read_port.sv
module bw_read_port
  import bw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [HW-1:0] hpos_i,
  input  logic [VW-1:0] vpos_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rsel;

  always_comb begin
    rsel = '0;
    unique case (addr_i)
      IDX_POS_HI: rsel = DW'(vpos_i >> 8);
      IDX_POS_LO: rsel = {hpos_i, vpos_i[7:0]};
      default:    rsel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_i ? rsel : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/beam_window_unit.sv
module beam_window_unit
  import bw_pkg::*;
#(
  parameter int unsigned H_BASE  = 227,
  parameter int unsigned V_LINES = 262
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [7:0]    addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  output logic          disp_win_o,
  output logic          fetch_win_o
);
  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  win_lim_t      lim;

  bw_beam_counter #(
    .H_BASE (H_BASE),
    .V_LINES(V_LINES),
    .HW     (HW),
    .VW     (VW)
  ) u_beam (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step_i),
    .hpos_o(hpos),
    .vpos_o(vpos)
  );

  bw_window_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .lim_o  (lim)
  );

  bw_window_cmp #(.FETCH_SH(1)) u_cmp (
    .hpos_i (hpos),
    .vpos_i (vpos),
    .lim_i  (lim),
    .disp_o (disp_win_o),
    .fetch_o(fetch_win_o)
  );

  bw_read_port u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .addr_i (addr_i),
    .hpos_i (hpos),
    .vpos_i (vpos),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/bw_checker.sv
module bw_checker
  import bw_pkg::*;
#(
  parameter int unsigned H_BASE  = 227,
  parameter int unsigned V_LINES = 262
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          step_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [HW-1:0] hpos,
  input logic [VW-1:0] vpos,
  input win_lim_t      lim
);
  localparam logic [HW-1:0] H_END = HW'(H_BASE - 1);
  localparam logic [VW-1:0] V_END = VW'(V_LINES - 1);

  // R2
  h_in_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpos <= H_END + HW'(vpos[0]));

  // R2
  hold_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(hpos) && $stable(vpos));

  // R3
  line_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && (hpos == H_END + HW'(vpos[0])) |=>
      hpos == '0 && vpos == (($past(vpos) == V_END) ? '0 : $past(vpos) + 1'b1));

  // R3
  v_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpos <= V_END);

  // R6
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0);

  // R8
  stop_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == IDX_WIN_END |=>
      lim.h_end[8] && (lim.v_end[8] == !$past(wdata_i[15])));

  // R9
  fetch_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == IDX_FET_BEG |=> lim.f_beg == {$past(wdata_i[7:2]), 3'b000});
endmodule

bind beam_window_unit bw_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .step_i (step_i),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .hpos   (hpos),
  .vpos   (vpos),
  .lim    (lim)
);

// File: tb/beam_window_unit_tb.sv
module beam_window_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        disp_win_o;
  logic        fetch_win_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side beam model and decoded limits
  int mh = 0, mv = 0;
  int hs = 0, he = 0, vs = 0, ve = 0, fs = 0, fe = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #10 clk_i = ~clk_i;

  beam_window_unit u_dut (
    .clk_i, .rst_ni, .step_i, .addr_i, .rd_i, .wr_i, .wdata_i,
    .rdata_o, .disp_win_o, .fetch_win_o
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(posedge clk_i) rd_seen <= rd_i;
  always @(negedge clk_i) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard underflow", int'(rdata_o), 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata_o === e, t, int'(rdata_o), int'(e));
      end
    end
  end

  function automatic bit exp_disp();
    return (mh >= hs) && (mh < he) && (mv >= vs) && (mv < ve);
  endfunction

  function automatic bit exp_fetch();
    return (fs <= 2 * mh) && (2 * mh <= fe);
  endfunction

  task automatic check_flags();
    check(disp_win_o === exp_disp(), "R10 display flag", int'(disp_win_o), int'(exp_disp()));
    check(fetch_win_o === exp_fetch(), "R11 fetch flag", int'(fetch_win_o), int'(exp_fetch()));
  endtask

  task automatic run_steps(int n, bit chk);
    for (int i = 0; i < n; i++) begin
      step_i = 1'b1;
      @(negedge clk_i);
      mh++;
      if (mh == 227 + (mv & 1)) begin
        mh = 0;
        mv = (mv + 1) % 262;
      end
      if (chk) check_flags();
    end
    step_i = 1'b0;
  endtask

  task automatic do_read(logic [7:0] idx, string tag);
    logic [15:0] e;
    case (idx)
      8'h02:   e = 16'(mv >> 8);
      8'h03:   e = {8'(mh), 8'(mv & 8'hff)};
      default: e = 16'h0000;
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    addr_i = idx;
    rd_i   = 1'b1;
    @(negedge clk_i);
    rd_i   = 1'b0;
  endtask

  task automatic do_write(logic [7:0] idx, logic [15:0] d);
    addr_i  = idx;
    wdata_i = d;
    wr_i    = 1'b1;
    @(negedge clk_i);
    wr_i    = 1'b0;
    case (idx)
      8'h47: begin hs = d[7:0]; vs = d[15:8]; end
      8'h48: begin he = 256 + d[7:0]; ve = (d[15] ? 0 : 256) + d[15:8]; end
      8'h49: fs = (d[7:2]) * 8;
      8'h4A: fe = (d[7:2]) * 8;
      default: ;
    endcase
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 outputs during reset
    check(rdata_o === 16'h0, "R1 rdata in reset", int'(rdata_o), 0);
    check(disp_win_o === 1'b0, "R1 disp in reset", int'(disp_win_o), 0);
    check(fetch_win_o === 1'b1, "R1 fetch in reset", int'(fetch_win_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_flags();
    do_read(8'h03, "R1 position low after reset");
    do_read(8'h02, "R1 position high after reset");
    do_read(8'h12, "R6 unmapped read");
    @(negedge clk_i);
    check(rdata_o === 16'h0, "R6 rdata idle", int'(rdata_o), 0);

    // R2 no step, no movement
    repeat (5) @(negedge clk_i);
    do_read(8'h03, "R2 hold without step");

    // R2/R3 line lengths by parity
    run_steps(226, 1'b1);
    do_read(8'h03, "R2 even line last position");
    run_steps(1, 1'b1);
    do_read(8'h03, "R3 even line wrap");
    run_steps(227, 1'b1);
    do_read(8'h03, "R2 odd line last position");
    run_steps(1, 1'b1);
    do_read(8'h03, "R3 odd line wrap");

    // R6 writes to position words are ignored
    do_write(8'h03, 16'hFFFF);
    do_write(8'h02, 16'hFFFF);
    do_read(8'h03, "R6 position write ignored");

    // R7/R8/R9 program windows
    do_write(8'h47, 16'h3040);
    do_write(8'h48, 16'h10A0);
    do_write(8'h49, 16'h0028);
    do_write(8'h4A, 16'h00D3);
    check_flags();

    // one full frame plus margin, flags checked every step
    for (int k = 0; k < 62; k++) begin
      run_steps(997, 1'b1);
      do_read(8'h03, "R5 position low in frame");
      do_read(8'h02, "R4 position high in frame");
    end

    // reach line 256+ explicitly for R4
    while (mv != 258) run_steps(1, 1'b0);
    do_read(8'h02, "R4 ninth vertical bit");
    do_read(8'h03, "R5 low word at line 258");

    // R8 stop with msb set, R9 unreachable fetch start
    do_write(8'h47, 16'h10E0);
    do_write(8'h48, 16'h8005);
    do_write(8'h49, 16'h00FF);
    check_flags();
    while (mv != 0) run_steps(1, 1'b1);
    for (int k = 0; k < 32; k++) begin
      run_steps(997, 1'b1);
      do_read(8'h03, "R3 position after frame wrap");
    end

    // R8 vertical stop reaching bit 8 from a clear msb
    do_write(8'h47, 16'h0000);
    do_write(8'h48, 16'h0505);
    do_write(8'h49, 16'h0000);
    do_write(8'h4A, 16'h00FF);
    while (mv != 259) run_steps(1, 1'b0);
    run_steps(2 * 228, 1'b1);

    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule